// File: doc/BRIEF.md
# NAND Bus Strobe Timing Generator

This block paces single byte or word accesses on an asynchronous NAND flash bus. Each accepted request drives the chip select of one bank low and holds it there for a setup interval. The block then pulses either the read strobe or the write strobe low for a width interval, raises it again, and waits a hold interval before it releases the chip select. All three intervals are counted in clock cycles and come from one packed 32-bit timing word.

The timing word is sampled when a request is accepted. Only its three count fields are kept, in a masked active copy, and that copy is rewritten only when the incoming fields differ from it. Edits to the word while an access is running therefore wait for the next access. A one-cycle done pulse closes each access. A request presented during that pulse is taken at once, so accesses can run back to back with the chip select high for a single cycle between them. The data bus itself, ECC, DMA and command sequencing are handled by other logic.

Top module: `nand_strobe_timer`

## Requirements
- R1: During and directly after reset every csN bit, rdN and wrN are high and done is low.
- R2: After a request is accepted on a clock edge, csN of the chosen bank is low and both strobes are high for S cycles, where S is bits 17:12 of the timing word, counted from the cycle after that edge.
- R3: The strobe then stays low for W cycles, where W is bits 10:5 of the timing word.
- R4: The strobe then rises and csN stays low for H more cycles, where H is bits 4:0 of the timing word, before csN returns high.
- R5: A count field of zero gives a phase of one cycle, so the access lasts at least three cycles with csN low.
- R6: reqWrite = 0 pulses rdN and reqWrite = 1 pulses wrN, the other strobe stays high, and rdN and wrN are never low together.
- R7: During an access only csN[reqBank] is low, with reqBank latched at acceptance, and every other csN bit stays high.
- R8: Bits 31:18 and bit 11 of the timing word have no effect on any phase length.
- R9: The timing word is sampled at acceptance, and a change to it later in the same access does not alter that access.
- R10: done is high for exactly the one cycle after csN returns high. A request held high in that cycle is accepted on its closing edge, so csN falls again on the following cycle.
- R11: A request raised while an access is in progress, and dropped before done, is ignored: no further access follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Request an access; taken when idle or in the done cycle |
| reqWrite | input | 1 | 0 selects a read strobe, 1 a write strobe |
| reqBank | input | BANK_W (2) | Bank whose chip select is driven |
| timingWord | input | 32 | Packed setup, width and hold counts |
| done | output | 1 | One-cycle pulse that ends an access |
| csN | output | NUM_BANKS (4) | Active-low chip selects, one per bank |
| rdN | output | 1 | Active-low read strobe |
| wrN | output | 1 | Active-low write strobe |

## Verification
Two events can share a cycle. The done pulse of one access can coincide with acceptance of the next request, and a change of the timing word can coincide with the acceptance edge or any cycle of a running access. The bench provokes the first by raising a new request exactly in the done cycle. It then expects csN to be high for that single cycle and low again in the next one, with the phases timed from the new word. The second is provoked by replacing the timing word in the first cycle after acceptance, and each cycle is then judged against phase lengths computed only from the word that was present at acceptance.

// File: rtl/nst_pkg.sv
package nst_pkg;

  // Default field layout of the packed timing word
  localparam int TIMING_W_DEF  = 32;
  localparam int SETUP_LSB_DEF = 12;
  localparam int SETUP_W_DEF   = 6;
  localparam int PULSE_LSB_DEF = 5;
  localparam int PULSE_W_DEF   = 6;
  localparam int HOLD_LSB_DEF  = 0;
  localparam int HOLD_W_DEF    = 5;

  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETUP  = 3'd1,
    PH_STROBE = 3'd2,
    PH_HOLD   = 3'd3,
    PH_DONE   = 3'd4
  } phase_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;      // latch request, load setup count
    logic loadPulse;   // load strobe-width count
    logic loadHold;    // load hold count
    logic countDown;   // decrement phase counter
    logic csOn;        // chip select low in the next cycle
    logic strobeOn;    // strobe low in the next cycle
    logic doneOn;      // done high in the next cycle
  } ctl_s;

endpackage

// File: rtl/nst_ctrl.sv
module nst_ctrl
  import nst_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic cntZero,
  output ctl_s ctl
);

  phase_e phase, phaseNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phase <= PH_IDLE;
    else       phase <= phaseNext;
  end

  always_comb begin
    phaseNext     = phase;
    ctl           = '0;
    unique case (phase)
      PH_IDLE, PH_DONE: begin
        if (reqValid) begin
          phaseNext  = PH_SETUP;
          ctl.accept = 1'b1;
        end else begin
          phaseNext  = PH_IDLE;
        end
      end
      PH_SETUP: begin
        if (cntZero) begin
          phaseNext     = PH_STROBE;
          ctl.loadPulse = 1'b1;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      PH_STROBE: begin
        if (cntZero) begin
          phaseNext    = PH_HOLD;
          ctl.loadHold = 1'b1;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      PH_HOLD: begin
        if (cntZero) phaseNext     = PH_DONE;
        else         ctl.countDown = 1'b1;
      end
      default: phaseNext = PH_IDLE;
    endcase

    ctl.csOn     = (phaseNext == PH_SETUP) || (phaseNext == PH_STROBE) ||
                   (phaseNext == PH_HOLD);
    ctl.strobeOn = (phaseNext == PH_STROBE);
    ctl.doneOn   = (phaseNext == PH_DONE);
  end

endmodule

// File: rtl/nst_datapath.sv
module nst_datapath
  import nst_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int BANK_W    = 2,
  parameter int TIMING_W  = TIMING_W_DEF,
  parameter int SETUP_LSB = SETUP_LSB_DEF,
  parameter int SETUP_W   = SETUP_W_DEF,
  parameter int PULSE_LSB = PULSE_LSB_DEF,
  parameter int PULSE_W   = PULSE_W_DEF,
  parameter int HOLD_LSB  = HOLD_LSB_DEF,
  parameter int HOLD_W    = HOLD_W_DEF
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctl_s                 ctl,
  input  logic                 reqWrite,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [TIMING_W-1:0]  timingWord,
  output logic                 cntZero,
  output logic [NUM_BANKS-1:0] csN,
  output logic                 rdN,
  output logic                 wrN,
  output logic                 done
);

  localparam int CNT_W = (SETUP_W > PULSE_W) ?
                         ((SETUP_W > HOLD_W) ? SETUP_W : HOLD_W) :
                         ((PULSE_W > HOLD_W) ? PULSE_W : HOLD_W);

  function automatic logic [TIMING_W-1:0] fieldBits(input int lsb, input int wd);
    logic [TIMING_W-1:0] m;
    m = '0;
    for (int i = 0; i < TIMING_W; i++)
      if (i >= lsb && i < lsb + wd) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [TIMING_W-1:0] FIELD_MASK =
    fieldBits(SETUP_LSB, SETUP_W) | fieldBits(PULSE_LSB, PULSE_W) |
    fieldBits(HOLD_LSB, HOLD_W);

  // Counter load value: field length minus one, zero field acts as one
  function automatic logic [CNT_W-1:0] phaseLoad(input logic [TIMING_W-1:0] w,
                                                 input int lsb, input int wd);
    logic [TIMING_W-1:0] f;
    f = (w >> lsb) & fieldBits(0, wd);
    if (f == '0) return '0;
    return CNT_W'(f - 1'b1);
  endfunction

  logic [TIMING_W-1:0] maskedReq;
  logic [TIMING_W-1:0] activeTiming;
  logic                timingDiff;
  logic [CNT_W-1:0]    cnt;
  logic [BANK_W-1:0]   bankQ;
  logic [BANK_W-1:0]   bankSel;
  logic                writeQ;

  assign maskedReq  = timingWord & FIELD_MASK;
  assign timingDiff = (maskedReq != activeTiming);
  assign bankSel    = ctl.accept ? reqBank : bankQ;
  assign cntZero    = (cnt == '0);

  // Active timing copy, rewritten only on a changed request at acceptance
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeTiming <= '0;
    end else if (ctl.accept && timingDiff) begin
      activeTiming <= maskedReq;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bankQ  <= '0;
      writeQ <= 1'b0;
    end else if (ctl.accept) begin
      bankQ  <= reqBank;
      writeQ <= reqWrite;
    end
  end

  // Phase counter: setup load uses the incoming word, later phases the copy
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.accept) begin
      cnt <= phaseLoad(maskedReq, SETUP_LSB, SETUP_W);
    end else if (ctl.loadPulse) begin
      cnt <= phaseLoad(activeTiming, PULSE_LSB, PULSE_W);
    end else if (ctl.loadHold) begin
      cnt <= phaseLoad(activeTiming, HOLD_LSB, HOLD_W);
    end else if (ctl.countDown) begin
      cnt <= cnt - 1'b1;
    end
  end

  // Registered bus outputs
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_cs
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) csN[b] <= 1'b1;
      else       csN[b] <= ~(ctl.csOn && (bankSel == BANK_W'(b)));
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdN  <= 1'b1;
      wrN  <= 1'b1;
      done <= 1'b0;
    end else begin
      rdN  <= ~(ctl.strobeOn && !writeQ);
      wrN  <= ~(ctl.strobeOn &&  writeQ);
      done <= ctl.doneOn;
    end
  end

endmodule

// File: rtl/nand_strobe_timer.sv
module nand_strobe_timer
  import nst_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int TIMING_W  = TIMING_W_DEF,
  parameter int SETUP_LSB = SETUP_LSB_DEF,
  parameter int SETUP_W   = SETUP_W_DEF,
  parameter int PULSE_LSB = PULSE_LSB_DEF,
  parameter int PULSE_W   = PULSE_W_DEF,
  parameter int HOLD_LSB  = HOLD_LSB_DEF,
  parameter int HOLD_W    = HOLD_W_DEF,
  localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [BANK_W-1:0]    reqBank,
  input  logic [TIMING_W-1:0]  timingWord,
  output logic                 done,
  output logic [NUM_BANKS-1:0] csN,
  output logic                 rdN,
  output logic                 wrN
);

  ctl_s ctl;
  logic cntZero;

  nst_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .cntZero  (cntZero),
    .ctl      (ctl)
  );

  nst_datapath #(
    .NUM_BANKS (NUM_BANKS),
    .BANK_W    (BANK_W),
    .TIMING_W  (TIMING_W),
    .SETUP_LSB (SETUP_LSB),
    .SETUP_W   (SETUP_W),
    .PULSE_LSB (PULSE_LSB),
    .PULSE_W   (PULSE_W),
    .HOLD_LSB  (HOLD_LSB),
    .HOLD_W    (HOLD_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqWrite   (reqWrite),
    .reqBank    (reqBank),
    .timingWord (timingWord),
    .cntZero    (cntZero),
    .csN        (csN),
    .rdN        (rdN),
    .wrN        (wrN),
    .done       (done)
  );

endmodule

// File: rtl/nst_checker.sv
module nst_checker #(
  parameter int NUM_BANKS = 4
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_BANKS-1:0] csN,
  input logic                 rdN,
  input logic                 wrN,
  input logic                 done
);

  // R6: never both strobes low
  a_r6_one_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !(!rdN && !wrN));

  // R6: a strobe is low only inside a chip-select window
  a_r6_strobe_in_cs: assert property (@(posedge clk) disable iff (!rstN)
    (!rdN || !wrN) |-> !(&csN));

  // R7: at most one bank selected
  a_r7_onehot_cs: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(~csN));

  // R7: the selected bank does not change inside an access
  a_r7_cs_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!(&csN) && !$past(&csN)) |-> $stable(csN));

  // R2: the strobe falls only after chip select was already low
  a_r2_setup_first: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(rdN) || $fell(wrN)) |-> !$past(&csN));

  // R4: chip select rises only after a cycle with both strobes high
  a_r4_hold_before_release: assert property (@(posedge clk) disable iff (!rstN)
    $rose(&csN) |-> $past(rdN && wrN));

  // R10: done follows directly on the chip-select release
  a_r10_done_at_release: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ((&csN) && !$past(&csN)));

  // R10: done lasts one cycle
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind nand_strobe_timer nst_checker #(.NUM_BANKS(NUM_BANKS)) u_chk (
  .clk  (clk),
  .rstN (rstN),
  .csN  (csN),
  .rdN  (rdN),
  .wrN  (wrN),
  .done (done)
);

// File: tb/sim_nand_strobe_timer.sv
`timescale 1ns/1ps
module sim_nand_strobe_timer;

  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [1:0]    reqBank = '0;
  logic [31:0]   timingWord = '0;
  logic          done;
  logic [NB-1:0] csN;
  logic          rdN;
  logic          wrN;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  nand_strobe_timer u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqBank(reqBank), .timingWord(timingWord), .done(done),
    .csN(csN), .rdN(rdN), .wrN(wrN)
  );

  function automatic int lenS(input logic [31:0] w);
    return (w[17:12] == 0) ? 1 : int'(w[17:12]);
  endfunction
  function automatic int lenW(input logic [31:0] w);
    return (w[10:5] == 0) ? 1 : int'(w[10:5]);
  endfunction
  function automatic int lenH(input logic [31:0] w);
    return (w[4:0] == 0) ? 1 : int'(w[4:0]);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic issue(input bit dir, input logic [1:0] bank, input logic [31:0] w);
    reqValid   = 1'b1;
    reqWrite   = dir;
    reqBank    = bank;
    timingWord = w;
    @(posedge clk);
  endtask

  // Follow one access cycle by cycle from the acceptance edge
  task automatic track(input bit dir, input logic [1:0] bank, input logic [31:0] w,
                       input string lbl, input bit mid, input bit poke, input bit chain);
    int s, pw, h, t;
    s = lenS(w); pw = lenW(w); h = lenH(w); t = s + pw + h;
    for (int k = 1; k <= t + 1; k++) begin
      logic [NB-1:0] eCs;
      bit sLow;
      string ph;
      @(negedge clk);
      eCs  = (k <= t) ? ~(NB'(1) << bank) : '1;
      sLow = (k > s) && (k <= s + pw);
      ph   = (k <= s) ? "R2" : (k <= s + pw) ? "R3" : (k <= t) ? "R4" : "R10";
      chk(csN == eCs, {lbl, " ", (k <= t) ? "R7" : "R10", " csN"}, 32'(csN), 32'(eCs));
      chk({rdN, wrN} == {!(sLow && !dir), !(sLow && dir)},
          {lbl, " ", ph, "/R6 strobes"}, 32'({rdN, wrN}),
          32'({!(sLow && !dir), !(sLow && dir)}));
      chk(done == (k == t + 1), {lbl, " R10 done"}, 32'(done), 32'(k == t + 1));
      if (k == 1) begin
        reqValid = 1'b0;
        if (mid) timingWord = $urandom;
      end
      if (poke && k == 2) reqValid = 1'b1;
      if (poke && k == 3) reqValid = 1'b0;
    end
    if (!chain) begin
      @(negedge clk);
      chk(&csN && rdN && wrN && !done, {lbl, " R11 idle after access"},
          32'({csN, rdN, wrN, done}), 32'({{NB{1'b1}}, 3'b110}));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R10 watchdog expired: actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd1234));
    repeat (3) begin
      @(negedge clk);
      chk(&csN && rdN && wrN && !done, "R1 in reset",
          32'({csN, rdN, wrN, done}), 32'({{NB{1'b1}}, 3'b110}));
    end
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(&csN && rdN && wrN && !done, "R1 after reset",
        32'({csN, rdN, wrN, done}), 32'({{NB{1'b1}}, 3'b110}));

    // All fields zero: one cycle each
    issue(1'b0, 2'd0, 32'h0);          track(1'b0, 2'd0, 32'h0, "R5", 0, 0, 0);
    issue(1'b1, 2'd2, 32'h0);          track(1'b1, 2'd2, 32'h0, "R5", 0, 0, 0);
    // All fields at maximum
    issue(1'b1, 2'd3, 32'h0003F7FF);   track(1'b1, 2'd3, 32'h0003F7FF, "R3", 0, 0, 0);
    // Reserved bits set, then cleared with identical fields
    w = {14'h3FFF, 6'd2, 1'b1, 6'd3, 5'd4};
    issue(1'b0, 2'd1, w);              track(1'b0, 2'd1, w, "R8", 0, 0, 0);
    w = {14'h0, 6'd2, 1'b0, 6'd3, 5'd4};
    issue(1'b0, 2'd1, w);              track(1'b0, 2'd1, w, "R8", 0, 0, 0);
    // Word replaced mid-access
    w = {14'h0, 6'd5, 1'b0, 6'd1, 5'd7};
    issue(1'b1, 2'd2, w);              track(1'b1, 2'd2, w, "R9", 1, 0, 0);
    // Request poked while busy, minimum length access
    issue(1'b0, 2'd3, 32'h0);          track(1'b0, 2'd3, 32'h0, "R11", 0, 1, 0);
    // Back-to-back accesses in the done cycle
    w = {14'h0, 6'd1, 1'b0, 6'd2, 5'd1};
    issue(1'b0, 2'd1, w);              track(1'b0, 2'd1, w, "R10", 0, 0, 1);
    w = {14'h0, 6'd3, 1'b0, 6'd0, 5'd2};
    issue(1'b1, 2'd0, w);              track(1'b1, 2'd0, w, "R10", 0, 0, 0);

    // Random accesses
    for (int n = 0; n < 80; n++) begin
      bit d, m, p, c;
      logic [1:0] b;
      d = 1'($urandom); b = 2'($urandom); w = $urandom;
      m = ($urandom % 3) == 0; p = ($urandom % 4) == 0;
      c = (($urandom % 4) == 0) && (n != 79);
      issue(d, b, w);
      track(d, b, w, "R2 rand", m, p, c);
    end
    reqValid = 1'b0;
    repeat (2) @(negedge clk);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule